// File: doc/BRIEF.md
# Two-wire serial memory slave controller

This block is the bus-side protocol engine of a serial memory device on a two-wire bus. A fast system clock oversamples the clock line and the data line, and the block pulls the data line low through an open-drain enable. It recognises start and stop conditions. It matches the device word against a fixed device code and three strap inputs. It receives the two-byte memory address and the write bytes, and it acknowledges every byte it accepts. On reads it shifts stored bytes out most significant bit first.

A memory-side engine is attached behind the block. It receives one write strobe per data byte, carrying the address and the data. It sees a stop strobe whenever a transfer ends. It returns read data combinationally for the address the block presents. It also raises a busy input while its internal write cycle runs. While busy is high the block withholds the acknowledge of its device word, so a bus master can poll until the write has finished.

The block keeps a single address counter. A write increments only the address bits within the 64-byte page and wraps inside that page. A read increments the full address and wraps at the end of the array. A random read is a write header carrying the address, then a repeated start and a read device word.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start condition, and a rising data line while the clock line is high is a stop. A stop seen while the block is not idle returns it to idle, releases the line and gives a one-cycle `stop_o` pulse.
- R2: The device word is compared bit 7 down to bit 1. Bits 7..4 must equal 1010 and bits 3..1 must equal `strap_i[2:0]`. Bit 0 selects read (1) or write (0). On a mismatch the ninth clock stays released and the block goes idle.
- R3: For each byte the block accepts, it pulls the data line low during the ninth clock. The pull-down only ever begins while the clock line is low.
- R4: After a write device word, two address bytes follow, high byte first. Only the low `AW` bits of {high, low} are kept, so the top bit of the high byte is ignored when AW is 15.
- R5: Each data byte after the address gives exactly one single-cycle `wr_en_o` pulse, with `wr_addr_o` and `wr_data_o` holding the address and the byte.
- R6: During a write the address advances only in bits 5..0. The byte after page offset 63 goes to offset 0 of the same page.
- R7: Read bytes leave most significant bit first, starting at the current address. After each byte the address advances by one and wraps from the last array address to 0. A following current-address read continues from there.
- R8: If the master answers a read byte with 1, the block keeps the line released for all further clocks until a start or a stop arrives.
- R9: A write header with two address bytes, followed by a repeated start and a read device word, makes the first read byte come from the address just loaded.
- R10: While `busy_i` is high at the end of the device word, no acknowledge is given and the block goes idle.
- R11: A start in the middle of a byte abandons the transfer in progress and begins a new device-word phase.
- R12: After reset the line is released, no strobes are active and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Hard-wired device select bits |
| busy_i | input | 1 | Memory engine is in its internal write cycle |
| wr_en_o | output | 1 | One-cycle strobe per received data byte |
| wr_addr_o | output | AW | Address of the strobed write byte |
| wr_data_o | output | 8 | Data of the strobed write byte |
| rd_req_o | output | 1 | Read data at `rd_addr_o` is latched this cycle |
| rd_addr_o | output | AW | Current address counter |
| rd_data_i | input | 8 | Memory byte at `rd_addr_o`, same cycle |
| stop_o | output | 1 | One-cycle pulse on a stop that ends a transfer |

## Verification
The checker watches, on every cycle, the properties that do not depend on a whole transaction. The pull-down may only start while the synchronised clock line is low. Idle and after-nack phases must keep the line released. A write strobe lasts one cycle. A stop strobe leaves the block idle. A busy device-word phase ends without an acknowledge. Only the bench's scenarios can show the parts that span whole transactions. These are the address byte order and masking, the page wrap of writes, the array wrap of reads, random and current-address reads with their byte values, strap and code mismatches, and abort by a mid-byte repeated start.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEV   = 3'd1,
    ST_ADDRH = 3'd2,
    ST_ADDRL = 3'd3,
    ST_WDATA = 3'd4,
    ST_RDATA = 3'd5,
    ST_WAIT  = 3'd6
  } state_t;
endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int AW     = 15,
  parameter int PAGE_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_hi,
  input  logic            ld_lo,
  input  logic [AW-9:0]   hi_in,
  input  logic [7:0]      lo_in,
  input  logic            inc_page,
  input  logic            inc_lin,
  output logic [AW-1:0]   addr_o
);
  localparam int HI_W = AW - 8;

  logic [HI_W-1:0] hi_q, hi_n;
  logic [AW-1:0]   addr_q, addr_n;
  logic [PAGE_W-1:0] pg_next;

  assign pg_next = addr_q[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};

  always_comb begin
    hi_n   = hi_q;
    addr_n = addr_q;
    if (ld_hi) hi_n = hi_in;
    if (ld_lo)         addr_n = {hi_q, lo_in};
    else if (inc_lin)  addr_n = addr_q + {{(AW-1){1'b0}}, 1'b1};
    else if (inc_page) addr_n = {addr_q[AW-1:PAGE_W], pg_next};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      hi_q   <= hi_n;
      addr_q <= addr_n;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int AW          = 15,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [2:0]    strap_i,
  input  logic          busy_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          stop_o
);
  localparam int HI_W = AW - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twi_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  state_t st, st_n;
  logic [3:0] cnt, cnt_n;
  logic [7:0] sr, sr_n;
  logic oe, oe_n, nack, nack_n, stop_q, stop_n;
  logic wr_en, wr_en_n;
  logic [AW-1:0] wr_addr, wr_addr_n, addr;
  logic [7:0] wr_data, wr_data_n;
  logic ld_hi, ld_lo, inc_pg, inc_ln, rd_req;

  twi_addr_ctr #(.AW(AW), .PAGE_W(PAGE_W)) i_addr (
    .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .hi_in(sr[HI_W-1:0]), .lo_in(sr), .inc_page(inc_pg), .inc_lin(inc_ln),
    .addr_o(addr)
  );

  // next-state logic
  always_comb begin
    st_n = st; cnt_n = cnt; sr_n = sr; oe_n = oe; nack_n = nack;
    wr_en_n = 1'b0; wr_addr_n = wr_addr; wr_data_n = wr_data;
    ld_hi = 1'b0; ld_lo = 1'b0; inc_pg = 1'b0; inc_ln = 1'b0; rd_req = 1'b0;
    stop_n = 1'b0;
    if (stop_det) begin
      stop_n = (st != ST_IDLE);
      st_n = ST_IDLE; oe_n = 1'b0; cnt_n = '0;
    end else if (start_det) begin
      st_n = ST_DEV; oe_n = 1'b0; cnt_n = '0;
    end else begin
      case (st)
        ST_DEV, ST_ADDRH, ST_ADDRL, ST_WDATA: begin
          if (scl_rise && cnt < 4'd9) begin
            cnt_n = cnt + 4'd1;
            if (cnt < 4'd8) sr_n = {sr[6:0], sda_s};
          end
          if (scl_fall && cnt == 4'd8) begin
            oe_n = 1'b1;
            case (st)
              ST_DEV: begin
                if (sr[7:4] != DEV_CODE || sr[3:1] != strap_i || busy_i) begin
                  oe_n = 1'b0; st_n = ST_IDLE; cnt_n = '0;
                end
              end
              ST_ADDRH: ld_hi = 1'b1;
              ST_ADDRL: ld_lo = 1'b1;
              default: begin
                wr_en_n = 1'b1; wr_addr_n = addr; wr_data_n = sr; inc_pg = 1'b1;
              end
            endcase
          end else if (scl_fall && cnt == 4'd9) begin
            oe_n = 1'b0; cnt_n = '0;
            case (st)
              ST_DEV: begin
                if (sr[0]) begin
                  st_n = ST_RDATA; sr_n = rd_data_i; rd_req = 1'b1; oe_n = ~rd_data_i[7];
                end else st_n = ST_ADDRH;
              end
              ST_ADDRH: st_n = ST_ADDRL;
              default:  st_n = ST_WDATA;
            endcase
          end
        end
        ST_RDATA: begin
          if (scl_rise && cnt < 4'd9) begin
            cnt_n = cnt + 4'd1;
            if (cnt == 4'd8) nack_n = sda_s;
          end
          if (scl_fall) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              sr_n = {sr[6:0], 1'b0}; oe_n = ~sr[6];
            end else if (cnt == 4'd8) begin
              oe_n = 1'b0; inc_ln = 1'b1;
            end else if (cnt == 4'd9) begin
              cnt_n = '0;
              if (!nack) begin
                sr_n = rd_data_i; rd_req = 1'b1; oe_n = ~rd_data_i[7];
              end else st_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sr <= '0; oe <= 1'b0; nack <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; stop_q <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sr <= sr_n; oe <= oe_n; nack <= nack_n;
      wr_en <= wr_en_n; wr_addr <= wr_addr_n; wr_data <= wr_data_n; stop_q <= stop_n;
    end
  end

  assign sda_oe_o  = oe;
  assign wr_en_o   = wr_en;
  assign wr_addr_o = wr_addr;
  assign wr_data_o = wr_data;
  assign rd_req_o  = rd_req;
  assign rd_addr_o = addr;
  assign stop_o    = stop_q;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       busy_i,
  input logic       sda_oe_o,
  input logic       wr_en_o,
  input logic       stop_o,
  input state_t     st,
  input logic [3:0] cnt
);
  p_pull_in_low_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_s);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe_o);

  p_stop_goes_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (st == ST_IDLE));

  p_write_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  p_busy_withholds_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV && cnt == 4'd8 && scl_fall && busy_i) |=> (st == ST_IDLE && !sda_oe_o));

  p_nack_keeps_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_oe_o);
endmodule

bind twi_mem_slave twi_mem_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall), .busy_i(busy_i),
  .sda_oe_o(sda_oe_o), .wr_en_o(wr_en_o), .stop_o(stop_o), .st(st), .cnt(cnt)
);

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;
  localparam int AW = 15;
  localparam int H  = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DW_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DW_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda_m, busy;
  logic sda_oe, wr_en, rd_req, stop_p;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_line;
  int nchk = 0, nfail = 0, stop_cnt = 0;
  logic [AW+7:0] exp_q[$];
  logic [AW+7:0] e;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  function automatic logic [7:0] memf(input logic [AW-1:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction
  assign rd_data = memf(rd_addr);

  twi_mem_slave #(.AW(AW)) i_twi_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(STRAP), .busy_i(busy), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .stop_o(stop_p)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic m_start();
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tick(H); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(H); ack = sda_line; scl = 1'b1; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(H); d[i] = sda_line; scl = 1'b1; tick(H); scl = 1'b0; tick(2);
    end
    send_bit(mack);
  endtask

  task automatic push_wr(input logic [AW-1:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  // scoreboard monitor for write strobes and stop pulses
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write strobe", {9'd0, wr_addr, wr_data}, 32'd0);
      else begin
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} == e, "R5/R6 write address+data", {9'd0, wr_addr, wr_data}, {9'd0, e});
      end
    end
    if (rst_n && stop_p) stop_cnt++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int s0;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; busy = 1'b0;
    tick(5);
    // R12 reset state
    chk(sda_oe == 1'b0, "R12 line released in reset", {31'd0, sda_oe}, 32'd0);
    chk(wr_en == 1'b0 && stop_p == 1'b0 && rd_addr == '0, "R12 strobes idle, address 0",
        {wr_en, stop_p, 15'd0, rd_addr}, 32'd0);
    rst_n = 1'b1;
    tick(5);

    // R4 R5 R6 page write with masked top bit and page wrap
    push_wr(15'h413E, 8'h11);
    push_wr(15'h413F, 8'h22);
    push_wr(15'h4100, 8'h33);
    s0 = stop_cnt;
    m_start();
    send_byte(DW_W, ack);  chk(ack == 1'b0, "R2/R3 device word acknowledged", {31'd0, ack}, 32'd0);
    send_byte(8'hC1, ack); chk(ack == 1'b0, "R4 high address acknowledged", {31'd0, ack}, 32'd0);
    send_byte(8'h3E, ack); chk(ack == 1'b0, "R4 low address acknowledged", {31'd0, ack}, 32'd0);
    send_byte(8'h11, ack); chk(ack == 1'b0, "R3 data acknowledged", {31'd0, ack}, 32'd0);
    send_byte(8'h22, ack); chk(ack == 1'b0, "R3 data acknowledged", {31'd0, ack}, 32'd0);
    send_byte(8'h33, ack); chk(ack == 1'b0, "R6 data after page end acknowledged", {31'd0, ack}, 32'd0);
    m_stop();
    tick(4);
    chk(stop_cnt == s0 + 1, "R1 stop pulse after write", stop_cnt, s0 + 1);
    chk(exp_q.size() == 0, "R5 all write strobes seen", exp_q.size(), 32'd0);

    // R2 wrong device code and wrong strap
    m_start(); send_byte(8'hBA, ack); m_stop();
    chk(ack == 1'b1, "R2 wrong device code not acknowledged", {31'd0, ack}, 32'd1);
    m_start(); send_byte({4'b1010, 3'b001, 1'b0}, ack); m_stop();
    chk(ack == 1'b1, "R2 wrong strap not acknowledged", {31'd0, ack}, 32'd1);

    // R10 busy polling
    busy = 1'b1;
    m_start(); send_byte(DW_W, ack); m_stop();
    chk(ack == 1'b1, "R10 busy withholds acknowledge", {31'd0, ack}, 32'd1);
    busy = 1'b0;
    m_start(); send_byte(DW_W, ack); m_stop();
    chk(ack == 1'b0, "R10 acknowledged once not busy", {31'd0, ack}, 32'd0);

    // R9 R7 random read crossing the end of the array
    m_start();
    send_byte(DW_W, ack);
    send_byte(8'h7F, ack);
    send_byte(8'hFE, ack);
    m_start();
    send_byte(DW_R, ack); chk(ack == 1'b0, "R9 read device word acknowledged", {31'd0, ack}, 32'd0);
    recv_byte(1'b0, d); chk(d == memf(15'h7FFE), "R9 first byte from loaded address", d, memf(15'h7FFE));
    recv_byte(1'b0, d); chk(d == memf(15'h7FFF), "R7 sequential next byte", d, memf(15'h7FFF));
    recv_byte(1'b1, d); chk(d == memf(15'h0000), "R7 wrap to address 0", d, memf(15'h0000));
    // R8 after nack the line stays released
    recv_byte(1'b1, d); chk(d == 8'hFF, "R8 no data after nack", d, 8'hFF);
    m_stop();

    // R7 current-address read continues after the last byte
    m_start();
    send_byte(DW_R, ack);
    recv_byte(1'b1, d); chk(d == memf(15'h0001), "R7 current address read", d, memf(15'h0001));
    m_stop();

    // R11 repeated start partway through a device word
    m_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    m_start();
    send_byte(DW_W, ack); chk(ack == 1'b0, "R11 new device phase after abort", {31'd0, ack}, 32'd0);
    s0 = stop_cnt;
    m_stop();
    tick(4);
    chk(stop_cnt == s0 + 1, "R1 stop after header ends transfer", stop_cnt, s0 + 1);
    chk(sda_oe == 1'b0, "R1 line released after stop", {31'd0, sda_oe}, 32'd0);

    tick(10);
    finish_run();
  end
endmodule